// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

The block turns a fast input clock into a one-cycle-wide tick (a clock enable) that repeats every N input cycles, where N is a programmable integer from 1 to 8. Several copies of the block that share an external alignment strobe can be forced back to the same phase. After that they tick on the same input cycle, so the downstream samplers they gate capture data together.

Configuration arrives through a single write port that loads the divide ratio and a two-bit alignment mode together. Alignment can be switched off. It can also realign the divider on every rising edge of the strobe. In the third choice, a configuration write arms the divider, only the first rising strobe edge after that write realigns it, and a done flag then reports the completed alignment. A new ratio never cuts a period short. It is adopted only when the current period ends or when an alignment event restarts the counter.

The alignment logic is a three-state machine. ARM_IDLE covers the disabled and every-edge modes. ARM_WAIT means armed, waiting for an edge. ARM_DONE means the one-time alignment has happened. Any configuration write jumps to ARM_WAIT when both mode bits are set, and to ARM_IDLE otherwise (transition "write"). In ARM_WAIT an accepted rising edge moves the machine to ARM_DONE (transition "fire"). ARM_IDLE and ARM_DONE stay where they are until the next write.

Top module: `phase_sync_divider`

## Requirements
- R1: With `cfg_div_m1` loaded with value v (0 to 7), the divide ratio is N = v+1 and `tick` is high for exactly one cycle out of every N.
- R2: While reset is held and in the first cycle after reset, the counter is at zero, so `tick` is high. The ratio resets to 1 (`cfg_div_m1` = 0), the mode resets to 00 and `sync_done` is low.
- R3: When mode bit 0 (enable) is 0, rising edges on `sync_in` have no effect on the tick phase. This holds whatever the value of bit 1.
- R4: In mode 01 (enable set, bit 1 clear), every rising edge of `sync_in` realigns the divider. If `sync_in` is first sampled high at clock edge k, the counter is zero after edge k+2, so `tick` is high in that cycle and again every N cycles after it.
- R5: In mode 11, a configuration write arms the divider. Only the first rising edge after the write realigns it, with the latency of R4, and that edge sets `sync_done`. Later edges are ignored until the next write.
- R6: `sync_done` is cleared by every configuration write and otherwise holds its value.
- R7: `sync_in` passes through a two-flop synchronizer and an edge detector, so a level held high for many cycles counts as one event.
- R8: A newly written ratio takes effect at the next counter wrap or at the next accepted alignment event, whichever comes first, so no shortened period appears.
- R9: With a ratio of 1, `tick` is high on every cycle, and alignment events cause no visible change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Asynchronous alignment strobe |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_div_m1 | input | 3 | Divide ratio minus one |
| cfg_mode | input | 2 | Bit 0 enables alignment, bit 1 selects first-edge-only |
| tick | output | 1 | Divided output, high one cycle per period |
| sync_done | output | 1 | One-time alignment has completed since the last write |

## Verification
The hardest part to observe is whether an alignment event actually happened, because a realignment that lands on the counter's natural zero is invisible at the ports. The stimulus therefore waits for a tick, raises the strobe on the next cycle, and uses a ratio of 5. A realignment then produces a tick one cycle before the natural one, and an ignored event leaves the natural tick in place. The same timing, combined with a mid-period ratio write, separates adoption at a wrap from adoption on an alignment event.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_WAIT = 2'd1,
        ARM_DONE = 2'd2
    } arm_state_e;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_ONCE_BIT = 1;
endpackage

// File: rtl/sdiv_sync_in.sv
module sdiv_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_async,
    output logic sync_rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], sync_async};
        end
    end

    assign sync_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/sdiv_arm_fsm.sv
module sdiv_arm_fsm
    import sdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] mode_wr,
    input  logic [1:0] mode_q,
    input  logic       sync_rise,
    output logic       sync_fire,
    output logic       sync_done
);
    arm_state_e state, state_nx;
    logic       accept;

    // an edge is accepted when enabled and either every-edge mode or armed
    assign accept = sync_rise & mode_q[MODE_EN_BIT] &
                    (~mode_q[MODE_ONCE_BIT] | (state == ARM_WAIT));

    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_IDLE: state_nx = ARM_IDLE;
            ARM_WAIT: if (accept) state_nx = ARM_DONE;
            ARM_DONE: state_nx = ARM_DONE;
            default:  state_nx = ARM_IDLE;
        endcase
        if (cfg_we) begin
            state_nx = (mode_wr[MODE_EN_BIT] & mode_wr[MODE_ONCE_BIT]) ? ARM_WAIT : ARM_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        sync_fire = accept;
        sync_done = (state == ARM_DONE);
    end
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_pend,
    input  logic          sync_fire,
    output logic [RW-1:0] cnt,
    output logic [RW-1:0] ratio_act,
    output logic          tick
);
    logic wrap;

    assign wrap = (cnt == ratio_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            ratio_act <= '0;
        end else if (sync_fire || wrap) begin
            cnt       <= '0;
            ratio_act <= ratio_pend;
        end else begin
            cnt <= cnt + RW'(1);
        end
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/phase_sync_divider.sv
module phase_sync_divider #(
    parameter int MAX_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_in,
    input  logic                       cfg_we,
    input  logic [$clog2(MAX_DIV)-1:0] cfg_div_m1,
    input  logic [1:0]                 cfg_mode,
    output logic                       tick,
    output logic                       sync_done
);
    localparam int RW = $clog2(MAX_DIV);

    logic [RW-1:0] ratio_pend;
    logic [1:0]    mode_q;
    logic          sync_rise;
    logic          sync_fire;
    logic [RW-1:0] cnt_w;
    logic [RW-1:0] ratio_act_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_pend <= '0;
            mode_q     <= '0;
        end else if (cfg_we) begin
            ratio_pend <= cfg_div_m1;
            mode_q     <= cfg_mode;
        end
    end

    sdiv_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_async (sync_in),
        .sync_rise  (sync_rise)
    );

    sdiv_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .mode_wr   (cfg_mode),
        .mode_q    (mode_q),
        .sync_rise (sync_rise),
        .sync_fire (sync_fire),
        .sync_done (sync_done)
    );

    sdiv_counter #(.RW(RW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_pend (ratio_pend),
        .sync_fire  (sync_fire),
        .cnt        (cnt_w),
        .ratio_act  (ratio_act_w),
        .tick       (tick)
    );
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    mode_q,
    input logic          sync_rise,
    input logic          sync_fire,
    input logic          tick,
    input logic          sync_done,
    input logic [RW-1:0] cnt,
    input logic [RW-1:0] ratio_act
);
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ratio_act);

    p_disabled_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] |-> !sync_fire);

    p_fire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fire |=> (cnt == '0) && tick);

    p_once_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_fire && mode_q[1] && !cfg_we) |=> sync_done);

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_done && !cfg_we) |=> sync_done);

    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !sync_done);

    p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> !sync_rise);

    p_ratio_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_act) |-> (cnt == '0));

    p_unit_ratio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_act == '0) |-> tick);
endmodule

bind phase_sync_divider sdiv_checker #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .mode_q    (mode_q),
    .sync_rise (sync_rise),
    .sync_fire (sync_fire),
    .tick      (tick),
    .sync_done (sync_done),
    .cnt       (cnt_w),
    .ratio_act (ratio_act_w)
);

// File: tb/phase_sync_divider_bench.sv
module phase_sync_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_div_m1 = '0;
    logic [1:0] cfg_mode = '0;
    logic       tick;
    logic       sync_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    phase_sync_divider u_phase_sync_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .cfg_we     (cfg_we),
        .cfg_div_m1 (cfg_div_m1),
        .cfg_mode   (cfg_mode),
        .tick       (tick),
        .sync_done  (sync_done)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] m1, logic [1:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_div_m1 = m1; cfg_mode = mode;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tick(string req);
        bit seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) begin seen = 1'b1; break; end
        end
        if (!seen) chk({req, " tick seen"}, 0, 1);
    endtask

    // ratio 5 assumed: realign puts a tick at t0+4, otherwise it stays at t0+5
    task automatic sync_probe(bit realign, string req);
        wait_tick(req);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        @(negedge clk);
        @(negedge clk); chk({req, " tick at t0+4"}, tick, realign);
        @(negedge clk); chk({req, " tick at t0+5"}, tick, !realign);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        settle(3);
        chk("R2 tick in reset", tick, 1);
        chk("R2 done in reset", sync_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 tick after reset", tick, 1);
        chk("R2 done after reset", sync_done, 0);
    endtask

    task automatic test_periods();
        for (int m = 0; m < 8; m++) begin
            int gap = 0;
            cfg_write(3'(m), 2'b00);
            settle(10);
            wait_tick("R1");
            do begin
                @(negedge clk);
                gap++;
            end while (!tick && gap < 20);
            chk($sformatf("R1 period for v=%0d", m), gap, m + 1);
        end
    endtask

    task automatic test_disabled();
        cfg_write(3'd4, 2'b00);
        settle(10);
        sync_probe(1'b0, "R3 mode 00");
        cfg_write(3'd4, 2'b10);
        settle(10);
        sync_probe(1'b0, "R3 mode 10");
    endtask

    task automatic test_every();
        cfg_write(3'd4, 2'b01);
        settle(10);
        sync_probe(1'b1, "R4 first edge");
        settle(3);
        sync_probe(1'b1, "R4 second edge");
    endtask

    task automatic test_held();
        int extra = 0;
        cfg_write(3'd4, 2'b01);
        settle(10);
        wait_tick("R7");
        @(negedge clk); sync_in = 1'b1;
        settle(3);
        chk("R7 realigned tick", tick, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (tick) extra++;
        end
        chk("R7 no repeat events", extra, 0);
        @(negedge clk); chk("R7 next tick", tick, 1);
        settle(5);      chk("R7 third tick", tick, 1);
        sync_in = 1'b0;
        settle(4);
    endtask

    task automatic test_once();
        cfg_write(3'd4, 2'b11);
        chk("R6 done cleared by write", sync_done, 0);
        settle(10);
        sync_probe(1'b1, "R5 armed edge");
        chk("R5 done set", sync_done, 1);
        sync_probe(1'b0, "R5 later edge ignored");
        chk("R6 done holds", sync_done, 1);
        cfg_write(3'd4, 2'b11);
        chk("R6 rewrite clears done", sync_done, 0);
        settle(10);
        sync_probe(1'b1, "R5 rearmed edge");
        chk("R5 done set again", sync_done, 1);
    endtask

    task automatic test_ratio_wrap();
        int early = 0;
        cfg_write(3'd7, 2'b00);
        settle(12);
        wait_tick("R8");
        @(negedge clk);
        @(negedge clk); cfg_we = 1'b1; cfg_div_m1 = 3'd2; cfg_mode = 2'b00;
        @(negedge clk); cfg_we = 1'b0;
        if (tick) early++;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (tick) early++;
        end
        chk("R8 no runt period", early, 0);
        @(negedge clk); chk("R8 old period ends", tick, 1);
        @(negedge clk); chk("R8 gap 1", tick, 0);
        @(negedge clk); chk("R8 gap 2", tick, 0);
        @(negedge clk); chk("R8 new period", tick, 1);
    endtask

    task automatic test_ratio_sync();
        cfg_write(3'd7, 2'b01);
        settle(12);
        wait_tick("R8 sync");
        @(negedge clk);
        cfg_we = 1'b1; cfg_div_m1 = 3'd2; cfg_mode = 2'b01; sync_in = 1'b1;
        @(negedge clk); cfg_we = 1'b0; sync_in = 1'b0;
        @(negedge clk);
        @(negedge clk); chk("R8 sync realign", tick, 1);
        @(negedge clk); chk("R8 sync gap 1", tick, 0);
        @(negedge clk); chk("R8 sync gap 2", tick, 0);
        @(negedge clk); chk("R8 ratio adopted on sync", tick, 1);
    endtask

    task automatic test_unit();
        int low = 0;
        cfg_write(3'd0, 2'b01);
        settle(10);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sync_in = (i == 1 || i == 2);
            if (!tick) low++;
        end
        chk("R9 tick every cycle", low, 0);
        sync_in = 1'b0;
    endtask

    initial begin
        test_reset();
        test_periods();
        test_disabled();
        test_every();
        test_held();
        test_once();
        test_ratio_wrap();
        test_ratio_sync();
        test_unit();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule